// File: doc/BRIEF.md
# Timer Core with Software Event Generation

This block is a 16-bit general-purpose timer core. It has a prescaler, a counter that counts up, down, or up-then-down (center-aligned), an auto-reload period register, and four capture/compare channels. A status register holds the event flags. Interrupt and DMA request lines are gated by enable bits. Software reaches the block through a single-cycle register write port and a combinational read port.

The central feature is a write-only, self-clearing event register. Software uses it to force an update, a capture/compare event on any channel, or a trigger event. A forced event has the same effect as the matching hardware event. A forced update re-initialises the counter according to mode and direction, clears the prescaler phase, and moves the preloaded period and prescaler values into their active copies. A forced capture on an input channel latches the live counter value and detects overcapture.

Register map (word addresses): 0 control (bit 0 run, bit 1 count down, bit 2 center-aligned), 1 enables (bits 6:0 interrupt enables and bits 14:8 DMA enables, each laid out like status bits 6:0), 2 status, 3 event, 4 channel direction (bit i = 1 makes channel i an input), 5 counter, 6 prescaler preload, 7 period preload, 8 to 11 channel registers 0 to 3, 12 active prescaler, 13 active period.

Top module: `tmr_evgen_core`

## Requirements
- R1: Reset state.
  - After reset every register reads 0.
  - `irq` is 0 and `dma_req` is 0.
- R2: Event register layout and handling.
  - Event bit 0 requests an update, bits 1 to 4 request events on channels 0 to 3, and bit 6 requests a trigger.
  - Writing 0 to an event bit does nothing, and writes to bit 5 and bits 15:7 have no effect.
  - The event register always reads 0.
- R3: A trigger request sets status bit 6. With its interrupt enable (enables bit 6) set, `irq` rises. With its DMA enable (enables bit 14) set, `dma_req[6]` rises.
- R4: A forced event on an output channel i sets status bit 1+i. It leaves that channel register unchanged.
- R5: A forced event on an input channel i copies the counter into channel register i and sets status bit 1+i. If status bit 1+i was already 1 before the write, it also sets overcapture bit 9+i.
- R6: A forced update loads the counter as follows, and clears the prescaler phase so that the next count step comes a full prescaler period later.
  - It loads 0 when the direction is up or center-aligned mode is set.
  - It loads the preloaded period when counting down in edge-aligned mode.
- R7: Every update, forced or natural, does two things in the same cycle.
  - It copies the prescaler and period preloads into their active registers.
  - It sets status bit 0.
- R8: When update and capture bits are written together, the update is applied first and the capture latches the re-initialised counter. All requested flags are set in that same cycle.
- R9: Status writes clear each bit written as 0 and keep each bit written as 1. A hardware event in the same cycle as a clear leaves its flag set.
- R10: Edge-aligned counting with run set and active prescaler P steps the counter once every P+1 cycles.
  - Counting up, it wraps from the active period to 0 with a natural update.
  - Counting down, it goes from 0 to the period preload with a natural update.
- R11: Center-aligned counting runs 0 up to the active period and back down to 0. It raises a natural update at each turning point.
- R12: An output channel whose register equals the counter at a count step sets its status flag.
- R13: Interrupt and DMA gating.
  - `irq` is the OR of status bits 6:0 masked by enables bits 6:0.
  - `dma_req` is status bits 6:0 masked by enables bits 14:8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write word address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 4 | Read word address |
| rd_data | output | 16 | Read data (combinational) |
| irq | output | 1 | Combined interrupt request |
| dma_req | output | 7 | DMA requests, one per status bit 6:0 (bit 5 always 0) |

## Verification
The bench targets the ordering cases first.

An update written together with a capture must give a captured value of 0 and not the old count. A design that sampled before re-initialising would latch a stale value. A natural update that coincides with a status clear must leave the update flag set; a design that ranked the clear higher would lose the event. Overcapture must depend on the flag value before the write, so a design that compared after setting would flag every capture.

A forced update in the middle of a prescaler period must restart the phase, and a design that skipped this would count early. The preloads must stay hidden until an update. A random phase then mixes counter writes, status clears, mode changes and event combinations against a bench model.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CNT_W  = 16;
    localparam int REG_W  = 16;
    localparam int NCH    = 4;
    localparam int ADDR_W = 4;

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [REG_W-1:0]  reg_t;
    typedef logic [ADDR_W-1:0] addr_t;

    localparam addr_t A_CTRL   = 4'd0;
    localparam addr_t A_IEN    = 4'd1;
    localparam addr_t A_STAT   = 4'd2;
    localparam addr_t A_EVT    = 4'd3;
    localparam addr_t A_CHMODE = 4'd4;
    localparam addr_t A_CNT    = 4'd5;
    localparam addr_t A_PSC    = 4'd6;
    localparam addr_t A_ARR    = 4'd7;
    localparam addr_t A_CCR0   = 4'd8;
    localparam addr_t A_PSCACT = 4'd12;
    localparam addr_t A_ARRACT = 4'd13;

    // status bit positions
    localparam int ST_UPD = 0;
    localparam int ST_CC0 = 1;
    localparam int ST_TRG = 6;
    localparam int ST_OC0 = 9;
    localparam reg_t ST_MASK = 16'h1E5F;

    localparam cnt_t CNT_ONE = cnt_t'(1);

    typedef struct packed {
        logic           upd;
        logic [NCH-1:0] cc;
        logic           trg;
    } evt_t;

    typedef struct packed {
        logic center;
        logic down;
        logic run;
    } ctrl_t;

    function automatic evt_t decode_evt(input reg_t d);
        evt_t e;
        e.upd = d[0];
        e.cc  = d[NCH:1];
        e.trg = d[6];
        return e;
    endfunction

    function automatic cnt_t reinit_val(input logic center, input logic down,
                                        input cnt_t period);
        return (center || !down) ? '0 : period;
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic clr,
    input  cnt_t ratio,
    output logic tick
);

    cnt_t phase_q;

    assign tick = run && !clr && (phase_q == ratio);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else if (clr) begin
            phase_q <= '0;
        end else if (run) begin
            phase_q <= (phase_q == ratio) ? '0 : phase_q + CNT_ONE;
        end
    end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic center,
    input  logic down,
    input  cnt_t arr_act,
    input  cnt_t arr_pre,
    input  logic force_upd,
    input  logic ld_en,
    input  cnt_t ld_val,
    output cnt_t cnt,
    output cnt_t cap_src,
    output logic nat_upd
);

    cnt_t cnt_q, cnt_nxt, reinit;
    logic cdn_q, cdn_nxt;

    assign reinit  = reinit_val(center, down, arr_pre);
    assign cap_src = force_upd ? reinit : cnt_q;
    assign cnt     = cnt_q;

    always_comb begin
        cnt_nxt = cnt_q;
        cdn_nxt = cdn_q;
        nat_upd = 1'b0;
        if (force_upd) begin
            cnt_nxt = reinit;
            cdn_nxt = 1'b0;
        end else if (ld_en) begin
            cnt_nxt = ld_val;
        end else if (tick) begin
            if (center) begin
                if (!cdn_q) begin
                    if (cnt_q >= arr_act) begin
                        nat_upd = 1'b1;
                        cdn_nxt = 1'b1;
                        cnt_nxt = (arr_act == '0) ? '0 : arr_act - CNT_ONE;
                    end else begin
                        cnt_nxt = cnt_q + CNT_ONE;
                    end
                end else begin
                    if (cnt_q == '0) begin
                        nat_upd = 1'b1;
                        cdn_nxt = 1'b0;
                        cnt_nxt = (arr_act == '0) ? '0 : CNT_ONE;
                    end else begin
                        cnt_nxt = cnt_q - CNT_ONE;
                    end
                end
            end else if (down) begin
                if (cnt_q == '0) begin
                    nat_upd = 1'b1;
                    cnt_nxt = arr_pre;
                end else begin
                    cnt_nxt = cnt_q - CNT_ONE;
                end
            end else begin
                if (cnt_q >= arr_act) begin
                    nat_upd = 1'b1;
                    cnt_nxt = '0;
                end else begin
                    cnt_nxt = cnt_q + CNT_ONE;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            cdn_q <= 1'b0;
        end else begin
            cnt_q <= cnt_nxt;
            cdn_q <= cdn_nxt;
        end
    end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic is_input,
    input  logic force_ev,
    input  logic tick,
    input  logic flag_now,
    input  logic ld_en,
    input  cnt_t cnt,
    input  cnt_t cap_src,
    input  cnt_t ld_val,
    output cnt_t ccr,
    output logic set_flag,
    output logic set_oc
);

    cnt_t ccr_q;

    assign ccr      = ccr_q;
    assign set_flag = force_ev || (!is_input && tick && (cnt == ccr_q));
    assign set_oc   = is_input && force_ev && flag_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            ccr_q <= '0;
        end else if (is_input && force_ev) begin
            ccr_q <= cap_src;
        end else if (!is_input && ld_en) begin
            ccr_q <= ld_val;
        end
    end

endmodule

// File: rtl/tmr_evgen_core.sv
module tmr_evgen_core
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    output logic              irq,
    output logic [6:0]        dma_req
);

    ctrl_t          ctrl_q;
    logic [6:0]     irq_en_q, dma_en_q;
    reg_t           stat_q, st_set, st_keep;
    logic [NCH-1:0] chmode_q;
    cnt_t           psc_pre_q, arr_pre_q, psc_act_q, arr_act_q;
    cnt_t           cnt_q, cap_src;
    cnt_t [NCH-1:0] ccr_q;
    logic [NCH-1:0] cc_set, oc_set;
    logic           tick, nat_upd, upd_any, wr_evt;
    evt_t           ev;

    assign wr_evt  = wr_en && (wr_addr == A_EVT);
    assign ev      = wr_evt ? decode_evt(wr_data) : '0;
    assign upd_any = ev.upd || nat_upd;

    tmr_prescaler u_psc (
        .clk   (clk),
        .rst   (rst),
        .run   (ctrl_q.run),
        .clr   (ev.upd),
        .ratio (psc_act_q),
        .tick  (tick)
    );

    tmr_counter u_cnt (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .center    (ctrl_q.center),
        .down      (ctrl_q.down),
        .arr_act   (arr_act_q),
        .arr_pre   (arr_pre_q),
        .force_upd (ev.upd),
        .ld_en     (wr_en && (wr_addr == A_CNT)),
        .ld_val    (wr_data),
        .cnt       (cnt_q),
        .cap_src   (cap_src),
        .nat_upd   (nat_upd)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam addr_t CH_ADDR = addr_t'(int'(A_CCR0) + i);
        tmr_channel u_ch (
            .clk      (clk),
            .rst      (rst),
            .is_input (chmode_q[i]),
            .force_ev (ev.cc[i]),
            .tick     (tick),
            .flag_now (stat_q[ST_CC0+i]),
            .ld_en    (wr_en && (wr_addr == CH_ADDR)),
            .cnt      (cnt_q),
            .cap_src  (cap_src),
            .ld_val   (wr_data),
            .ccr      (ccr_q[i]),
            .set_flag (cc_set[i]),
            .set_oc   (oc_set[i])
        );
    end

    // flag set vector and software clear mask
    always_comb begin
        st_set                        = '0;
        st_set[ST_UPD]                = upd_any;
        st_set[ST_CC0+NCH-1:ST_CC0]   = cc_set;
        st_set[ST_TRG]                = ev.trg;
        st_set[ST_OC0+NCH-1:ST_OC0]   = oc_set;
        st_keep = (wr_en && (wr_addr == A_STAT)) ? (stat_q & wr_data) : stat_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            irq_en_q  <= '0;
            dma_en_q  <= '0;
            stat_q    <= '0;
            chmode_q  <= '0;
            psc_pre_q <= '0;
            arr_pre_q <= '0;
            psc_act_q <= '0;
            arr_act_q <= '0;
        end else begin
            stat_q <= (st_keep | st_set) & ST_MASK;
            if (upd_any) begin
                psc_act_q <= psc_pre_q;
                arr_act_q <= arr_pre_q;
            end
            if (wr_en) begin
                case (wr_addr)
                    A_CTRL:   ctrl_q    <= ctrl_t'(wr_data[2:0]);
                    A_IEN: begin
                        irq_en_q <= wr_data[6:0];
                        dma_en_q <= wr_data[14:8];
                    end
                    A_CHMODE: chmode_q  <= wr_data[NCH-1:0];
                    A_PSC:    psc_pre_q <= wr_data;
                    A_ARR:    arr_pre_q <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (rd_addr)
            A_CTRL:   rd_data = {13'd0, ctrl_q};
            A_IEN:    rd_data = {1'b0, dma_en_q, 1'b0, irq_en_q};
            A_STAT:   rd_data = stat_q;
            A_CHMODE: rd_data = {{(REG_W-NCH){1'b0}}, chmode_q};
            A_CNT:    rd_data = cnt_q;
            A_PSC:    rd_data = psc_pre_q;
            A_ARR:    rd_data = arr_pre_q;
            A_PSCACT: rd_data = psc_act_q;
            A_ARRACT: rd_data = arr_act_q;
            default:  rd_data = (rd_addr[3:2] == 2'b10) ? ccr_q[rd_addr[1:0]] : '0;
        endcase
    end

    assign irq     = |(stat_q[6:0] & irq_en_q);
    assign dma_req = stat_q[6:0] & dma_en_q;

endmodule

// File: rtl/tmr_evgen_core_chk.sv
module tmr_evgen_core_chk
    import tmr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [REG_W-1:0]  wr_data,
    input cnt_t              cnt_q,
    input reg_t              stat_q,
    input cnt_t              ccr0,
    input cnt_t              arr_act_q,
    input cnt_t              arr_pre_q,
    input logic [2:0]        ctrl_bits,
    input logic [NCH-1:0]    chmode_q,
    input logic              upd_any
);

    logic evw;
    assign evw = wr_en && (wr_addr == A_EVT);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (cnt_q == '0 && stat_q == '0));

    // R3
    trg_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (evw && wr_data[6]) |=> stat_q[ST_TRG]);

    // R5
    capture_val_chk: assert property (@(posedge clk) disable iff (rst)
        (evw && wr_data[1] && !wr_data[0] && chmode_q[0]) |=> (ccr0 == $past(cnt_q)));

    // R5
    overcapture_chk: assert property (@(posedge clk) disable iff (rst)
        (evw && wr_data[1] && chmode_q[0] && stat_q[ST_CC0]) |=> stat_q[ST_OC0]);

    // R6
    upd_reinit_chk: assert property (@(posedge clk) disable iff (rst)
        (evw && wr_data[0] && (ctrl_bits[2] || !ctrl_bits[1])) |=> (cnt_q == '0));

    // R7
    preload_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        upd_any |=> (arr_act_q == $past(arr_pre_q) && stat_q[ST_UPD]));

    // R10
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_bits[0] && !(wr_en && (wr_addr == A_EVT || wr_addr == A_CNT)))
        |=> $stable(cnt_q));

endmodule

bind tmr_evgen_core tmr_evgen_core_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .cnt_q     (cnt_q),
    .stat_q    (stat_q),
    .ccr0      (ccr_q[0]),
    .arr_act_q (arr_act_q),
    .arr_pre_q (arr_pre_q),
    .ctrl_bits (ctrl_q),
    .chmode_q  (chmode_q),
    .upd_any   (upd_any)
);

// File: tb/tmr_evgen_core_tb.sv
`timescale 1ns/1ps
module tmr_evgen_core_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        irq;
    logic [6:0]  dma_req;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    tmr_evgen_core u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .dma_req(dma_req)
    );

    localparam logic [3:0] A_CTRL = 0, A_IEN = 1, A_STAT = 2, A_EVT = 3, A_CHMODE = 4,
                           A_CNT = 5, A_PSC = 6, A_ARR = 7, A_CCR0 = 8,
                           A_PSCACT = 12, A_ARRACT = 13;
    localparam logic [15:0] STM = 16'h1E5F;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // called at a falling edge; the write lands on the next rising edge
    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] reinit(input logic center, input logic down,
                                           input logic [15:0] period);
        return (center || !down) ? 16'h0 : period;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    logic [15:0] v;
    logic [15:0] m_cnt, m_stat, m_arr, old_stat;
    logic [15:0] m_ccr [4];
    logic [3:0]  m_mode;
    logic        m_center, m_down;
    int unsigned r;

    initial begin
        r = $urandom(32'd4242);
        wait_cyc(3);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(A_STAT, v);   chk("R1 status", v, 16'h0);
        rd(A_CNT, v);    chk("R1 counter", v, 16'h0);
        rd(A_ARRACT, v); chk("R1 active period", v, 16'h0);
        chk("R1 irq", {15'd0, irq}, 16'h0);
        chk("R1 dma", {9'd0, dma_req}, 16'h0);
        @(negedge clk);

        // R2 zero and reserved-only event writes are ignored
        wr(A_EVT, 16'h0000);
        wr(A_EVT, 16'hFFA0);
        rd(A_STAT, v); chk("R2 reserved bits no flags", v, 16'h0);
        rd(A_EVT, v);  chk("R2 event reads zero", v, 16'h0);
        @(negedge clk);

        // R7 preload hidden until update
        wr(A_PSC, 16'd2);
        wr(A_ARR, 16'd4);
        rd(A_ARRACT, v); chk("R7 period not yet active", v, 16'h0);
        @(negedge clk);
        wr(A_EVT, 16'h0001);
        rd(A_ARRACT, v); chk("R7 period active after update", v, 16'd4);
        rd(A_PSCACT, v); chk("R7 prescaler active after update", v, 16'd2);
        rd(A_STAT, v);   chk("R7 update flag", v, 16'h0001);
        @(negedge clk);

        // R3 trigger and gating (R13)
        wr(A_EVT, 16'h0040);
        rd(A_STAT, v); chk("R3 trigger flag", v, 16'h0041);
        chk("R13 irq disabled", {15'd0, irq}, 16'h0);
        @(negedge clk);
        wr(A_IEN, 16'h4040);
        chk("R3 irq enabled", {15'd0, irq}, 16'h1);
        chk("R3 dma trigger", {9'd0, dma_req}, 16'h0040);

        // R9 write-1 keeps, write-0 clears
        wr(A_STAT, 16'hFFFF);
        rd(A_STAT, v); chk("R9 write ones keep", v, 16'h0041);
        @(negedge clk);
        wr(A_STAT, 16'hFFBF);
        rd(A_STAT, v); chk("R9 clear trigger only", v, 16'h0001);
        @(negedge clk);
        wr(A_STAT, 16'h0000);
        wr(A_IEN, 16'h0000);

        // R4 output channel forced event
        wr(A_CCR0 + 4'd1, 16'h1234);
        wr(A_EVT, 16'h0004);
        rd(A_STAT, v); chk("R4 output flag", v, 16'h0004);
        rd(A_CCR0 + 4'd1, v); chk("R4 output register unchanged", v, 16'h1234);
        @(negedge clk);

        // R5 input capture with overcapture
        wr(A_CHMODE, 16'h0002);
        wr(A_CNT, 16'h0ABC);
        wr(A_EVT, 16'h0004);
        rd(A_CCR0 + 4'd1, v); chk("R5 captured value", v, 16'h0ABC);
        rd(A_STAT, v); chk("R5 overcapture set", v, 16'h0404);
        @(negedge clk);
        wr(A_STAT, 16'h0000);
        wr(A_CNT, 16'h0055);
        wr(A_EVT, 16'h0004);
        rd(A_CCR0 + 4'd1, v); chk("R5 second capture", v, 16'h0055);
        rd(A_STAT, v); chk("R5 no overcapture", v, 16'h0004);
        @(negedge clk);

        // R8 update + capture + trigger together
        wr(A_CNT, 16'h0777);
        wr(A_EVT, 16'h0045);
        rd(A_CNT, v); chk("R8 counter reinit", v, 16'h0);
        rd(A_CCR0 + 4'd1, v); chk("R8 capture sees reinit value", v, 16'h0);
        rd(A_STAT, v); chk("R8 all flags same cycle", v, 16'h0445);
        @(negedge clk);

        // R6 reinit values
        wr(A_STAT, 16'h0);
        wr(A_ARR, 16'd9);
        wr(A_CTRL, 16'h0002);
        wr(A_EVT, 16'h0001);
        rd(A_CNT, v); chk("R6 down loads period", v, 16'd9);
        @(negedge clk);
        wr(A_CTRL, 16'h0006);
        wr(A_CNT, 16'd5);
        wr(A_EVT, 16'h0001);
        rd(A_CNT, v); chk("R6 center loads zero", v, 16'd0);
        @(negedge clk);

        // R10 edge-aligned up counting, prescaler 2, period 4
        wr(A_CTRL, 16'h0000);
        wr(A_ARR, 16'd4);
        wr(A_PSC, 16'd2);
        wr(A_EVT, 16'h0001);
        wr(A_STAT, 16'h0);
        wr(A_CTRL, 16'h0001);
        wait_cyc(3);
        rd(A_CNT, v); chk("R10 first step", v, 16'd1);
        wait_cyc(11);
        rd(A_CNT, v); chk("R10 at period", v, 16'd4);
        rd(A_STAT, v); chk("R10 no update yet", v & 16'h1, 16'h0);
        wait_cyc(1);
        rd(A_CNT, v); chk("R10 wrap", v, 16'd0);
        rd(A_STAT, v); chk("R10 natural update", v & 16'h1, 16'h1);

        // R6 prescaler phase cleared by forced update
        wr(A_EVT, 16'h0001);
        wait_cyc(2);
        rd(A_CNT, v); chk("R6 phase restart hold", v, 16'd0);
        wait_cyc(1);
        rd(A_CNT, v); chk("R6 phase restart step", v, 16'd1);

        // R7 natural update transfers preload
        wr(A_ARR, 16'd6);
        rd(A_ARRACT, v); chk("R7 preload hidden while running", v, 16'd4);
        wait_cyc(30);
        rd(A_ARRACT, v); chk("R7 natural transfer", v, 16'd6);

        // R9 hardware set wins over clear
        wr(A_CTRL, 16'h0000);
        wr(A_PSC, 16'd0);
        wr(A_ARR, 16'd4);
        wr(A_EVT, 16'h0001);
        wr(A_EVT, 16'h0040);
        wr(A_CTRL, 16'h0001);
        wait_cyc(4);
        wr(A_STAT, 16'h0000);
        rd(A_STAT, v); chk("R9 update wins clear", v, 16'h0001);
        rd(A_CNT, v);  chk("R10 wrap at period 4", v, 16'd0);

        // R11 center-aligned, period 3
        wr(A_CTRL, 16'h0004);
        wr(A_ARR, 16'd3);
        wr(A_EVT, 16'h0001);
        wr(A_STAT, 16'h0);
        wr(A_CTRL, 16'h0005);
        wait_cyc(3);
        rd(A_CNT, v);  chk("R11 peak", v, 16'd3);
        rd(A_STAT, v); chk("R11 no update before turn", v & 16'h1, 16'h0);
        wait_cyc(1);
        rd(A_CNT, v);  chk("R11 descending", v, 16'd2);
        rd(A_STAT, v); chk("R11 update at peak", v & 16'h1, 16'h1);
        wait_cyc(2);
        rd(A_CNT, v);  chk("R11 valley", v, 16'd0);
        wait_cyc(1);
        rd(A_CNT, v);  chk("R11 ascending", v, 16'd1);

        // R12 output compare match
        wr(A_CTRL, 16'h0000);
        wr(A_CHMODE, 16'h0000);
        wr(A_CCR0, 16'd2);
        wr(A_EVT, 16'h0001);
        wr(A_STAT, 16'h0);
        wr(A_CTRL, 16'h0001);
        wait_cyc(2);
        rd(A_STAT, v); chk("R12 before match", v & 16'h2, 16'h0);
        wait_cyc(1);
        rd(A_STAT, v); chk("R12 match flag", v & 16'h2, 16'h2);
        wr(A_CTRL, 16'h0000);

        // R13 dma on update
        wr(A_STAT, 16'h0);
        wr(A_IEN, 16'h0100);
        wr(A_EVT, 16'h0001);
        chk("R13 dma update", {9'd0, dma_req}, 16'h0001);
        chk("R13 irq masked", {15'd0, irq}, 16'h0);
        wr(A_IEN, 16'h0000);

        // random phase: counter stopped, model of forced events (R2 R5 R6 R8 R9)
        for (int c = 0; c < 4; c++) wr(A_CCR0 + 4'(c), 16'h0);
        wr(A_ARR, 16'd0);
        wr(A_EVT, 16'h0001);
        wr(A_STAT, 16'h0);
        m_cnt = 0; m_stat = 0; m_arr = 0; m_mode = 0; m_center = 0; m_down = 0;
        for (int c = 0; c < 4; c++) m_ccr[c] = 0;
        for (int it = 0; it < 200; it++) begin
            r = $urandom;
            case (r % 7)
                0: begin wr(A_CNT, r[31:16]); m_cnt = r[31:16]; end
                1: begin wr(A_STAT, r[31:16]); m_stat = m_stat & r[31:16] & STM; end
                2: begin
                    wr(A_CTRL, {13'd0, r[9], r[8], 1'b0});
                    m_center = r[9]; m_down = r[8];
                end
                3: begin wr(A_CHMODE, {12'd0, r[11:8]}); m_mode = r[11:8]; end
                6: begin wr(A_ARR, r[31:16]); m_arr = r[31:16]; end
                default: begin
                    wr(A_EVT, r[31:16]);
                    old_stat = m_stat;
                    if (r[16]) begin
                        m_cnt = reinit(m_center, m_down, m_arr);
                        m_stat[0] = 1'b1;
                    end
                    for (int c = 0; c < 4; c++) begin
                        if (r[17+c]) begin
                            if (m_mode[c]) begin
                                m_ccr[c] = m_cnt;
                                if (old_stat[1+c]) m_stat[9+c] = 1'b1;
                            end
                            m_stat[1+c] = 1'b1;
                        end
                    end
                    if (r[22]) m_stat[6] = 1'b1;
                end
            endcase
            rd(A_CNT, v);  chk("R6 random counter", v, m_cnt);
            rd(A_STAT, v); chk("R5 random status", v, m_stat);
            for (int c = 0; c < 4; c++) begin
                rd(A_CCR0 + 4'(c), v);
                chk("R8 random channel register", v, m_ccr[c]);
            end
            @(negedge clk);
        end

        summary();
    end

endmodule